// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Flags

This block is the execute-stage datapath of a small three-stage RISC core. From two 32-bit operands, a 6-bit operation select and a 5-bit shift amount it forms a 32-bit result in the same cycle. It also tells the write-back logic whether that result should go to the register file.

A 32-bit status word sits next to the datapath. Its low four bits hold a zero indication, a carry/borrow indication, an odd-parity indication and a signed-overflow indication. The upper 28 bits are reserved and read as zero.

The control logic drives a flag-write enable. It raises this enable for instructions that write an ALU result back, and for compare. It holds the enable low for loads, stores and bubbles, so those leave the flags alone. Flag changes appear at the status output after the next rising clock edge.

Top module: `alu_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole status word to zero. Status bits 31 down to 4 read as zero at all times.
- R2: The operation codes are: add 0x01, subtract 0x02, AND 0x03, OR 0x04, XOR 0x05, compare 0x06, shift left 0x07, shift right 0x08, rotate left 0x09, rotate right 0x0A. Add gives a+b modulo 2^32. Subtract gives a-b modulo 2^32.
- R3: AND, OR and XOR give the bitwise combination of the two operands.
- R4: Shift left and shift right move operand a by the 5-bit amount (0 to 31), filling the vacated positions with zeros.
- R5: Rotate left and rotate right move operand a circularly by the 5-bit amount, across all 32 bits.
- R6: Status bit 0 is set after an update when the result was all zeros, and cleared otherwise.
- R7: Status bit 1 holds the carry-out of an add. For subtract and compare it holds the borrow, which is 1 exactly when a < b unsigned. Logical, shift and rotate operations clear it.
- R8: Status bit 2 is set after an update when the result held an odd number of ones, and cleared when it held an even number.
- R9: Status bit 3 is set when a signed add, subtract or compare overflowed 32 bits. All other operations clear it.
- R10: Compare drives the difference a-b on the result and updates the flags, but keeps the result write-enable low. Every other defined operation raises the result write-enable.
- R11: The flags change only on a rising edge where the flag-write enable is high and the operation code is defined. Otherwise the status word holds its value.
- R12: An undefined operation code gives a result of zero and a low result write-enable. It leaves the status word unchanged even when the flag-write enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 6 | Operation select |
| opnd_a | input | 32 | First operand; the value shifted or rotated |
| opnd_b | input | 32 | Second operand |
| shamt | input | 5 | Shift/rotate amount |
| flag_we | input | 1 | Flag-write enable from control |
| result | output | 32 | Combinational ALU result |
| result_we | output | 1 | Result should be written back |
| status | output | 32 | Registered status word |

## Verification
On every cycle, the assertions check four things. The reserved status bits stay zero. The status word holds whenever no update is allowed. The zero and parity flags agree with the result seen on the previous edge. Logical and shift operations leave carry and overflow clear, and compare never asks for a write-back.

The bench's scenarios are needed for the rest. These are the arithmetic values themselves, and carry, borrow and signed overflow at the wrap points. They also include the shift and rotate amounts at the 0 and 31 extremes, and the undefined-opcode case.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    localparam int unsigned OPC_W = 6;

    // Fixed status-word bit positions (software decodes these)
    localparam int unsigned FLG_ZERO = 0;
    localparam int unsigned FLG_CARRY = 1;
    localparam int unsigned FLG_PAR = 2;
    localparam int unsigned FLG_OVF = 3;
    localparam int unsigned FLG_CNT = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 6'h01,
        OP_SUB = 6'h02,
        OP_AND = 6'h03,
        OP_OR  = 6'h04,
        OP_XOR = 6'h05,
        OP_CMP = 6'h06,
        OP_SLL = 6'h07,
        OP_SRL = 6'h08,
        OP_ROL = 6'h09,
        OP_ROR = 6'h0A
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic par;
        logic carry;
        logic zero;
    } alu_flags_t;

    function automatic logic op_defined(input logic [OPC_W-1:0] code);
        return (code >= 6'h01) && (code <= 6'h0A);
    endfunction

    function automatic logic op_is_arith(input logic [OPC_W-1:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_CMP);
    endfunction

    function automatic logic op_is_sub(input logic [OPC_W-1:0] code);
        return (code == OP_SUB) || (code == OP_CMP);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = do_sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        sum   = wide[W-1:0];
        // carry-out for add; inverted carry-out is the borrow for subtract
        carry = do_sub ? ~wide[W] : wide[W];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [OPC_W-1:0] code,
    output logic [W-1:0]     y
);
    always_comb begin
        unique case (code)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift_rot.sv
module alu_shift_rot
    import alu_status_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned SH_W = $clog2(W)
) (
    input  logic [W-1:0]     a,
    input  logic [SH_W-1:0]  sh,
    input  logic [OPC_W-1:0] code,
    output logic [W-1:0]     y
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] dbl;
    logic [DW-1:0] dbl_l;
    logic [DW-1:0] dbl_r;

    always_comb begin
        dbl   = {a, a};
        dbl_l = dbl << sh;
        dbl_r = dbl >> sh;
        unique case (code)
            OP_SLL:  y = a << sh;
            OP_SRL:  y = a >> sh;
            OP_ROL:  y = dbl_l[DW-1:W];
            OP_ROR:  y = dbl_r[W-1:0];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd,
    input  alu_flags_t nxt,
    output logic [W-1:0] status
);
    alu_flags_t flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else if (upd) begin
            flg_q <= nxt;
        end
    end

    always_comb begin
        status = '0;
        status[FLG_ZERO]  = flg_q.zero;
        status[FLG_CARRY] = flg_q.carry;
        status[FLG_PAR]   = flg_q.par;
        status[FLG_OVF]   = flg_q.ovf;
    end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OPC_W-1:0]    op_code,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic                flag_we,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic [DATA_W-1:0]   status
);
    logic [DATA_W-1:0] as_y;
    logic [DATA_W-1:0] lg_y;
    logic [DATA_W-1:0] sr_y;
    logic              as_c;
    logic              as_v;
    logic              valid_op;
    logic              arith_op;
    alu_flags_t        flg_nxt;

    alu_addsub #(.W(DATA_W)) addsub_i (
        .a(opnd_a), .b(opnd_b), .do_sub(op_is_sub(op_code)),
        .sum(as_y), .carry(as_c), .ovf(as_v)
    );

    alu_logic #(.W(DATA_W)) logic_i (
        .a(opnd_a), .b(opnd_b), .code(op_code), .y(lg_y)
    );

    alu_shift_rot #(.W(DATA_W), .SH_W(SHAMT_W)) shrot_i (
        .a(opnd_a), .sh(shamt), .code(op_code), .y(sr_y)
    );

    always_comb begin
        valid_op = op_defined(op_code);
        arith_op = op_is_arith(op_code);
        if (arith_op) begin
            result = as_y;
        end else begin
            // unselected units drive zero, so OR picks the active one
            result = lg_y | sr_y;
        end
        result_we     = valid_op && (op_code != OP_CMP);
        flg_nxt.zero  = (result == '0);
        flg_nxt.par   = ^result;
        flg_nxt.carry = arith_op ? as_c : 1'b0;
        flg_nxt.ovf   = arith_op ? as_v : 1'b0;
    end

    alu_flag_reg #(.W(DATA_W)) flags_i (
        .clk(clk), .rst(rst), .upd(flag_we && valid_op),
        .nxt(flg_nxt), .status(status)
    );
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
    import alu_status_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] op_code,
    input logic             flag_we,
    input logic [W-1:0]     result,
    input logic             result_we,
    input logic [W-1:0]     status
);
    logic upd_ok;
    logic lgsh_op;
    assign upd_ok  = flag_we && op_defined(op_code);
    assign lgsh_op = op_defined(op_code) && !op_is_arith(op_code);

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (status == '0));
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[W-1:FLG_CNT] == '0);
    // R11
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !upd_ok |=> $stable(status));
    // R6
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        upd_ok |=> (status[FLG_ZERO] == ($past(result) == '0)));
    // R8
    p_parity_r8: assert property (@(posedge clk) disable iff (rst)
        upd_ok |=> (status[FLG_PAR] == $past(^result)));
    // R7 and R9
    p_logic_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_we && lgsh_op) |=> (!status[FLG_CARRY] && !status[FLG_OVF]));
    // R10
    p_cmp_no_wr_r10: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CMP) |-> !result_we);
    // R12
    p_undef_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !op_defined(op_code) |-> (result == '0 && !result_we));
endmodule

bind alu_status_unit alu_status_chk #(.W(DATA_W)) chk_i (.*);

// File: tb/alu_status_unit_tb_top.sv
`timescale 1ns/100ps
module alu_status_unit_tb_top;
    import alu_status_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic        flag_we = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic [31:0] status;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_status = '0;
    bit finished = 0;

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [31:0] st;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    alu_status_unit dut_i (
        .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .shamt(shamt), .flag_we(flag_we),
        .result(result), .result_we(result_we), .status(status)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference model
    task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, output logic [31:0] r, output logic we,
                         output logic ok, output logic c, output logic v);
        longint s;
        ok = 1; we = 1; c = 0; v = 0; r = 0;
        case (op)
            6'h01: begin
                r = a + b; c = ({1'b0, a} + {1'b0, b}) > 33'h0FFFFFFFF;
                s = longint'($signed(a)) + longint'($signed(b));
                v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            6'h02, 6'h06: begin
                r = a - b; c = (a < b);
                s = longint'($signed(a)) - longint'($signed(b));
                v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                if (op == 6'h06) we = 0;
            end
            6'h03: r = a & b;
            6'h04: r = a | b;
            6'h05: r = a ^ b;
            6'h07: for (int i = 0; i < 32; i++) if (i >= sh) r[i] = a[i-sh];
            6'h08: for (int i = 0; i < 32; i++) if (i + sh < 32) r[i] = a[i+sh];
            6'h09: for (int i = 0; i < 32; i++) r[(i+sh)%32] = a[i];
            6'h0A: for (int i = 0; i < 32; i++) r[i] = a[(i+sh)%32];
            default: begin ok = 0; we = 0; end
        endcase
    endtask

    // Driver: applies one operation on a falling edge and queues the expectation
    task automatic drive(input string tag, input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh, input logic fwe);
        item_t it;
        logic [31:0] r;
        logic we, ok, c, v;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; shamt = sh; flag_we = fwe;
        model(op, a, b, sh, r, we, ok, c, v);
        if (fwe && ok) begin
            exp_status = 32'h0;
            exp_status[0] = (r == 0);
            exp_status[1] = c;
            exp_status[2] = ^r;
            exp_status[3] = v;
        end
        it.res = r; it.we = we; it.st = exp_status; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: 1 ns after the edge, inputs still held, flags already updated
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check32({it.tag, " result"}, result, it.res);
                check32({it.tag, " result_we"}, {31'b0, result_we}, {31'b0, it.we});
                check32({it.tag, " status"}, status, it.st);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check32("R1 reset status", status, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        drive("R2 add small", 6'h01, 32'd1, 32'd1, 5'd0, 1);
        drive("R2 R6 R7 add wrap carry zero", 6'h01, 32'hFFFFFFFF, 32'd1, 5'd0, 1);
        drive("R9 add signed ovf", 6'h01, 32'h7FFFFFFF, 32'd1, 5'd0, 1);
        drive("R7 sub borrow", 6'h02, 32'd5, 32'd7, 5'd0, 1);
        drive("R9 sub signed ovf", 6'h02, 32'h80000000, 32'd1, 5'd0, 1);
        drive("R10 cmp equal", 6'h06, 32'h1234, 32'h1234, 5'd0, 1);
        drive("R10 cmp less", 6'h06, 32'd3, 32'd9, 5'd0, 1);
        drive("R3 and", 6'h03, 32'hF0F0FFFF, 32'h0FF0F00F, 5'd0, 1);
        drive("R3 or", 6'h04, 32'hF0000000, 32'h00000001, 5'd0, 1);
        drive("R3 R8 xor", 6'h05, 32'hAAAA5555, 32'h5555AAAB, 5'd0, 1);
        drive("R4 sll 0", 6'h07, 32'h80000001, 32'd0, 5'd0, 1);
        drive("R4 sll 31", 6'h07, 32'h00000003, 32'd0, 5'd31, 1);
        drive("R4 srl 31", 6'h08, 32'h80000000, 32'd0, 5'd31, 1);
        drive("R5 rol 1", 6'h09, 32'h80000001, 32'd0, 5'd1, 1);
        drive("R5 ror 0", 6'h0A, 32'h12345678, 32'd0, 5'd0, 1);
        drive("R5 ror 31", 6'h0A, 32'h80000001, 32'd0, 5'd31, 1);
        drive("R9 set ovf", 6'h01, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1);
        drive("R11 no flag_we", 6'h01, 32'd0, 32'd0, 5'd0, 0);
        drive("R12 undefined 3F", 6'h3F, 32'h1, 32'h1, 5'd3, 1);
        drive("R12 undefined 00", 6'h00, 32'hFFFFFFFF, 32'h0, 5'd0, 1);
        drive("R7 R9 logic clears", 6'h04, 32'h0, 32'h0, 5'd0, 1);

        for (int k = 0; k < 200; k++) begin
            logic [5:0] op;
            op = 6'((($urandom % 12)));
            drive("R2 R11 random", op, $urandom, $urandom, 5'($urandom), 1'($urandom));
        end

        @(negedge clk);
        flag_we = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check32("R1 reset mid-run", status, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule